// File: doc/BRIEF.md
# Controller Enable and Admin Register File

This block is the memory-mapped control register file of a queue-based storage controller. Software uses it to set and clear an interrupt mask, to program the admin queue sizes and the two 64-bit admin queue base addresses (each written as two 32-bit halves), and to write a configuration word. The capability and version words are read-only and come from parameters.

The configuration word acts on edges. When software sets the enable bit while it is clear, the block stores the word, runs a list of checks against the stored admin settings and the capability limits, and reports either ready or fatal in the status word. When software clears enable while it is set, or requests a shutdown, the block tears the queues down and reports the result. From the stored configuration word it drives the memory page size and the two queue entry sizes. It also emits one-cycle pulses that tell the command logic to build or to drop the admin queues.

Top module: `ctrl_admin_regs`

## Requirements
- R1: A write to offset 0x0C ORs the write data into the interrupt mask; reads of both 0x0C and 0x10 return the mask.
- R2: A write to offset 0x10 clears every mask bit that is set in the write data.
- R3: The configuration word lives at 0x14 (enable = bit 0, shutdown request = bits 15:14 nonzero). A write with enable and shutdown both clear, while the stored word also has both clear, just stores the data.
- R4: A write that sets enable while the stored enable is clear stores the data; if every check passes, the status word at 0x1C becomes exactly 0x1 (ready, bit 0) and `admin_setup` pulses high for one cycle starting the cycle after the write.
- R5: Validation fails, the status word becomes exactly 0x2 (fatal, bit 1) and no setup pulse occurs, if either admin base is zero or not a multiple of the page size, if the page-size field (bits 10:7) is outside the capability range, if the submission entry exponent (bits 19:16) or completion entry exponent (bits 23:20) is outside its supported range, or if either admin size field (0x24 bits 11:0 submission, bits 27:16 completion) is zero. Ready and fatal are never both set.
- R6: A write that clears enable while the stored enable is set pulses `queue_teardown`, zeroes the stored configuration word and clears only the ready bit (a fatal bit stays).
- R7: A write that requests shutdown while the stored word (after any enable handling in the same write) has none pulses `queue_teardown`, stores the data and sets status bit 3; a write without a shutdown request while the stored word has one clears bit 3 and stores the data.
- R8: 0x24 holds the admin queue sizes. The submission base is written at 0x28 (low) / 0x2C (high), the completion base at 0x30 / 0x34; a low-half write replaces the whole 64-bit base with the data zero-extended, a high-half write ORs the data into bits 63:32.
- R9: 0x08 reads 0x00010100; 0x00 reads 0x0F0307FF (maximum queue entries 0x7FF in bits 15:0) and 0x04 reads 0x00400020 with the default parameters.
- R10: `page_bytes` equals 2^(page-size field + 12) and the entry-size outputs equal 2^exponent, all taken from the stored configuration word.
- R11: Reads of any offset not listed above return zero, and writes to such offsets change no register.
- R12: An enabling write that also carries a shutdown request reports ready only: the shutdown-complete bit is not set and no teardown occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| page_bytes | output | 32 | Memory page size in bytes |
| sq_entry_bytes | output | 16 | Submission entry size in bytes |
| cq_entry_bytes | output | 16 | Completion entry size in bytes |
| admin_setup | output | 1 | One-cycle pulse: admin queues built |
| queue_teardown | output | 1 | One-cycle pulse: all queues dropped |

## Verification
The assertions assume one register access per cycle with the address held stable while the write strobe is high, and that the strobe is never X once reset is released; the bench drives every access a fixed delay after the rising edge and releases the strobe after exactly one cycle. They also take it that base alignment is judged against the page size named in the same enabling write, not the stored one, so the bench changes page size and bases only through complete writes and then enables. The stimulus walks each edge of the configuration word, including the combined disable-with-shutdown and enable-with-shutdown writes, and each validation rule in isolation.

// File: rtl/ctrl_admin_pkg.sv
package ctrl_admin_pkg;

  localparam int REG_W = 32;

  // register offsets (byte addresses)
  localparam logic [7:0] OFS_CAP_LO = 8'h00;
  localparam logic [7:0] OFS_CAP_HI = 8'h04;
  localparam logic [7:0] OFS_VER    = 8'h08;
  localparam logic [7:0] OFS_MSET   = 8'h0C;
  localparam logic [7:0] OFS_MCLR   = 8'h10;
  localparam logic [7:0] OFS_CFG    = 8'h14;
  localparam logic [7:0] OFS_STAT   = 8'h1C;
  localparam logic [7:0] OFS_AQA    = 8'h24;
  localparam logic [7:0] OFS_SQB_LO = 8'h28;
  localparam logic [7:0] OFS_CQB_LO = 8'h30;

  // configuration word field positions
  localparam int CFG_EN   = 0;
  localparam int CFG_MPS  = 7;
  localparam int CFG_SHN  = 14;
  localparam int CFG_SQES = 16;
  localparam int CFG_CQES = 20;

  // admin size field positions
  localparam int AQA_SQ = 0;
  localparam int AQA_CQ = 16;

  // status bits
  localparam int ST_RDY  = 0;
  localparam int ST_CFS  = 1;
  localparam int ST_SHDN = 3;
  localparam int ST_W    = 4;

  function automatic logic [31:0] page_bytes_f(input logic [3:0] mps);
    return 32'd1 << (32'(mps) + 32'd12);
  endfunction

  function automatic logic base_aligned_f(input logic [63:0] base, input logic [3:0] mps);
    logic [63:0] low_mask;
    low_mask = (64'd1 << (64'(mps) + 64'd12)) - 64'd1;
    return (base & low_mask) == 64'd0;
  endfunction

  function automatic logic [15:0] entry_bytes_f(input logic [3:0] expo);
    return 16'd1 << expo;
  endfunction

endpackage

// File: rtl/ctrl_irq_mask.sv
module ctrl_irq_mask
  import ctrl_admin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_wr,
  input  logic             clr_wr,
  input  logic [REG_W-1:0] data,
  output logic [REG_W-1:0] mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (set_wr) mask_q <= mask_q | data;
    else if (clr_wr) mask_q <= mask_q & ~data;
  end

  AST_MASK_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((mask_q & $past(data)) == $past(data))); // R1

  AST_MASK_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !set_wr) |=> ((mask_q & $past(data)) == '0)); // R2

endmodule

// File: rtl/ctrl_base_pair.sv
module ctrl_base_pair
  import ctrl_admin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_wr,
  input  logic             hi_wr,
  input  logic [REG_W-1:0] data,
  output logic [63:0]      base_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_q <= '0;
    else if (lo_wr) base_q <= {32'd0, data};
    else if (hi_wr) base_q[63:32] <= base_q[63:32] | data;
  end

  AST_LOW_CLEARS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> (base_q[63:32] == 32'd0)); // R8

  AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && !lo_wr) |=> (base_q[31:0] == $past(base_q[31:0]))); // R8

endmodule

// File: rtl/ctrl_cfg_check.sv
module ctrl_cfg_check #(
  parameter int MPS_MIN  = 0,
  parameter int MPS_MAX  = 4,
  parameter int SQES_MIN = 6,
  parameter int SQES_MAX = 6,
  parameter int CQES_MIN = 4,
  parameter int CQES_MAX = 4
) (
  input  logic [3:0]  mps,
  input  logic [3:0]  sqes,
  input  logic [3:0]  cqes,
  input  logic [63:0] sq_base,
  input  logic [63:0] cq_base,
  input  logic [11:0] sq_size,
  input  logic [11:0] cq_size,
  input  logic        queues_live,
  output logic        cfg_ok
);
  import ctrl_admin_pkg::*;

  // individual rule violations, named for debug and assertions
  logic bad_base_zero, bad_base_align, bad_page, bad_sqes, bad_cqes, bad_size, bad_live;

  always_comb begin
    bad_base_zero  = (sq_base == 64'd0) || (cq_base == 64'd0);
    bad_base_align = !base_aligned_f(sq_base, mps) || !base_aligned_f(cq_base, mps);
    bad_page       = (int'(mps) < MPS_MIN) || (int'(mps) > MPS_MAX);
    bad_sqes       = (int'(sqes) < SQES_MIN) || (int'(sqes) > SQES_MAX);
    bad_cqes       = (int'(cqes) < CQES_MIN) || (int'(cqes) > CQES_MAX);
    bad_size       = (sq_size == 12'd0) || (cq_size == 12'd0);
    bad_live       = queues_live;
    cfg_ok = !(bad_base_zero | bad_base_align | bad_page | bad_sqes |
               bad_cqes | bad_size | bad_live);
  end

endmodule

// File: rtl/ctrl_admin_regs.sv
module ctrl_admin_regs
  import ctrl_admin_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [15:0] MQES     = 16'h07FF,
  parameter logic [7:0]  TMO      = 8'h0F,
  parameter logic [7:0]  CSS      = 8'h01,
  parameter int          MPS_MIN  = 0,
  parameter int          MPS_MAX  = 4,
  parameter int          SQES_MIN = 6,
  parameter int          SQES_MAX = 6,
  parameter int          CQES_MIN = 4,
  parameter int          CQES_MAX = 4,
  parameter logic [31:0] VERSION  = 32'h0001_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [31:0]       page_bytes,
  output logic [15:0]       sq_entry_bytes,
  output logic [15:0]       cq_entry_bytes,
  output logic              admin_setup,
  output logic              queue_teardown
);

  localparam logic [31:0] CAP_LO = {TMO, 5'd0, 2'd1, 1'b1, MQES};
  localparam logic [31:0] CAP_HI = {8'd0, 4'(MPS_MAX), 4'(MPS_MIN), 3'd0, CSS, 5'd0};
  localparam int NBASE = 2;

  // address decode
  logic hit_mset, hit_mclr, hit_cfg, hit_aqa, hit_known;
  always_comb begin
    hit_mset  = bus_addr == ADDR_W'(OFS_MSET);
    hit_mclr  = bus_addr == ADDR_W'(OFS_MCLR);
    hit_cfg   = bus_addr == ADDR_W'(OFS_CFG);
    hit_aqa   = bus_addr == ADDR_W'(OFS_AQA);
    hit_known = hit_mset | hit_mclr | hit_cfg | hit_aqa |
                (bus_addr == ADDR_W'(OFS_CAP_LO)) | (bus_addr == ADDR_W'(OFS_CAP_HI)) |
                (bus_addr == ADDR_W'(OFS_VER))    | (bus_addr == ADDR_W'(OFS_STAT))   |
                (bus_addr >= ADDR_W'(OFS_SQB_LO) && bus_addr <= ADDR_W'(OFS_CQB_LO + 8'h4) &&
                 bus_addr[1:0] == 2'b00);
  end

  // interrupt mask
  logic [REG_W-1:0] mask_q;
  ctrl_irq_mask u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_wr(bus_wr && hit_mset), .clr_wr(bus_wr && hit_mclr),
    .data(bus_wdata), .mask_q(mask_q)
  );

  // admin base address pairs: index 0 submission, 1 completion
  logic [63:0] base_q [NBASE];
  for (genvar g = 0; g < NBASE; g++) begin : g_base
    localparam logic [7:0] LO_OFS = OFS_SQB_LO + 8'(8 * g);
    ctrl_base_pair u_pair (
      .clk(clk), .rst_n(rst_n),
      .lo_wr(bus_wr && bus_addr == ADDR_W'(LO_OFS)),
      .hi_wr(bus_wr && bus_addr == ADDR_W'(LO_OFS + 8'h4)),
      .data(bus_wdata), .base_q(base_q[g])
    );
  end

  // admin sizes
  logic [REG_W-1:0] aqa_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  aqa_q <= '0;
    else if (bus_wr && hit_aqa)  aqa_q <= bus_wdata;
  end

  // validation of the word being written
  logic live_q, cfg_ok;
  ctrl_cfg_check #(
    .MPS_MIN(MPS_MIN), .MPS_MAX(MPS_MAX), .SQES_MIN(SQES_MIN),
    .SQES_MAX(SQES_MAX), .CQES_MIN(CQES_MIN), .CQES_MAX(CQES_MAX)
  ) u_check (
    .mps(bus_wdata[CFG_MPS +: 4]), .sqes(bus_wdata[CFG_SQES +: 4]),
    .cqes(bus_wdata[CFG_CQES +: 4]),
    .sq_base(base_q[0]), .cq_base(base_q[1]),
    .sq_size(aqa_q[AQA_SQ +: 12]), .cq_size(aqa_q[AQA_CQ +: 12]),
    .queues_live(live_q), .cfg_ok(cfg_ok)
  );

  // configuration edge engine: the write is applied in steps, each step
  // seeing the configuration left by the one before it
  logic [REG_W-1:0] cfg_q, cfg_n;
  logic [ST_W-1:0]  stat_q, stat_n;
  logic             live_n, setup_n, down_n;
  logic             d_en, d_sh;

  always_comb begin
    cfg_n   = cfg_q;
    stat_n  = stat_q;
    live_n  = live_q;
    setup_n = 1'b0;
    down_n  = 1'b0;
    d_en    = bus_wdata[CFG_EN];
    d_sh    = bus_wdata[CFG_SHN +: 2] != 2'b00;
    if (bus_wr && hit_cfg) begin
      if (!d_en && !d_sh && !cfg_n[CFG_EN] && cfg_n[CFG_SHN +: 2] == 2'b00)
        cfg_n = bus_wdata;
      if (d_en && !cfg_n[CFG_EN]) begin
        cfg_n = bus_wdata;
        if (cfg_ok) begin
          stat_n  = ST_W'(1 << ST_RDY);
          setup_n = 1'b1;
          live_n  = 1'b1;
        end else begin
          stat_n  = ST_W'(1 << ST_CFS);
        end
      end else if (!d_en && cfg_n[CFG_EN]) begin
        cfg_n          = '0;
        stat_n[ST_RDY] = 1'b0;
        down_n         = 1'b1;
        live_n         = 1'b0;
      end
      if (d_sh && cfg_n[CFG_SHN +: 2] == 2'b00) begin
        cfg_n           = bus_wdata;
        stat_n[ST_SHDN] = 1'b1;
        down_n          = 1'b1;
        live_n          = 1'b0;
      end else if (!d_sh && cfg_n[CFG_SHN +: 2] != 2'b00) begin
        cfg_n           = bus_wdata;
        stat_n[ST_SHDN] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q          <= '0;
      stat_q         <= '0;
      live_q         <= 1'b0;
      admin_setup    <= 1'b0;
      queue_teardown <= 1'b0;
    end else begin
      cfg_q          <= cfg_n;
      stat_q         <= stat_n;
      live_q         <= live_n;
      admin_setup    <= setup_n;
      queue_teardown <= down_n;
    end
  end

  // derived sizes
  always_comb begin
    page_bytes     = page_bytes_f(cfg_q[CFG_MPS +: 4]);
    sq_entry_bytes = entry_bytes_f(cfg_q[CFG_SQES +: 4]);
    cq_entry_bytes = entry_bytes_f(cfg_q[CFG_CQES +: 4]);
  end

  // read mux
  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_CAP_LO):         bus_rdata = CAP_LO;
      ADDR_W'(OFS_CAP_HI):         bus_rdata = CAP_HI;
      ADDR_W'(OFS_VER):            bus_rdata = VERSION;
      ADDR_W'(OFS_MSET),
      ADDR_W'(OFS_MCLR):           bus_rdata = mask_q;
      ADDR_W'(OFS_CFG):            bus_rdata = cfg_q;
      ADDR_W'(OFS_STAT):           bus_rdata = REG_W'(stat_q);
      ADDR_W'(OFS_AQA):            bus_rdata = aqa_q;
      ADDR_W'(OFS_SQB_LO):         bus_rdata = base_q[0][31:0];
      ADDR_W'(OFS_SQB_LO + 8'h4):  bus_rdata = base_q[0][63:32];
      ADDR_W'(OFS_CQB_LO):         bus_rdata = base_q[1][31:0];
      ADDR_W'(OFS_CQB_LO + 8'h4):  bus_rdata = base_q[1][63:32];
      default:                     bus_rdata = '0;
    endcase
  end

  AST_SETUP_MEANS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    admin_setup |-> (stat_q[ST_RDY] && cfg_q[CFG_EN])); // R4

  AST_LIVE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> cfg_q[CFG_EN]); // R4

  AST_READY_FATAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_q[ST_RDY] && stat_q[ST_CFS])); // R5

  AST_FALL_TEARS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_cfg && !bus_wdata[CFG_EN] && cfg_q[CFG_EN])
      |=> (queue_teardown && !stat_q[ST_RDY])); // R6

  AST_SHUTDOWN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_cfg && bus_wdata[CFG_SHN +: 2] != 2'b00 && cfg_q[CFG_SHN +: 2] == 2'b00 &&
     !(bus_wdata[CFG_EN] && !cfg_q[CFG_EN])) |=> stat_q[ST_SHDN]); // R7

  AST_PULSES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({admin_setup, queue_teardown})); // R12

  AST_UNLISTED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit_known) |=> (cfg_q == $past(cfg_q) && aqa_q == $past(aqa_q) &&
                                mask_q == $past(mask_q) && stat_q == $past(stat_q))); // R11

endmodule

// File: tb/ctrl_admin_regs_tb.sv
module ctrl_admin_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, page_bytes;
  logic [15:0] sq_entry_bytes, cq_entry_bytes;
  logic        admin_setup, queue_teardown;

  always #5 clk = ~clk;

  ctrl_admin_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .page_bytes(page_bytes),
    .sq_entry_bytes(sq_entry_bytes), .cq_entry_bytes(cq_entry_bytes),
    .admin_setup(admin_setup), .queue_teardown(queue_teardown)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_mask, m_cc, m_aqa;
  logic [3:0]  m_stat;
  logic [63:0] m_sqb, m_cqb;
  bit          m_setup, m_down;

  function automatic bit m_valid(input logic [31:0] d);
    int unsigned mps = d[10:7];
    logic [63:0] page = 64'd1 << (mps + 12);
    if (m_sqb == 0 || m_cqb == 0) return 0;
    if ((m_sqb % page) != 0 || (m_cqb % page) != 0) return 0;
    if (mps > 4) return 0;
    if (d[19:16] != 4'd6 || d[23:20] != 4'd4) return 0;
    if (m_aqa[11:0] == 0 || m_aqa[27:16] == 0) return 0;
    return 1;
  endfunction

  task automatic m_cfg_write(input logic [31:0] d);
    bit want_on  = d[0];
    bit want_off = (d[15:14] != 0);
    if (!want_on && !want_off && !m_cc[0] && m_cc[15:14] == 0) m_cc = d;
    if (want_on && !m_cc[0]) begin
      m_cc = d;
      if (m_valid(d)) begin m_stat = 4'h1; m_setup = 1; end
      else m_stat = 4'h2;
    end else if (!want_on && m_cc[0]) begin
      m_cc = 0; m_stat[0] = 0; m_down = 1;
    end
    if (want_off && m_cc[15:14] == 0) begin
      m_cc = d; m_stat[3] = 1; m_down = 1;
    end else if (!want_off && m_cc[15:14] != 0) begin
      m_cc = d; m_stat[3] = 0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_cc = 0; m_aqa = 0; m_stat = 0; m_sqb = 0; m_cqb = 0;
      m_setup = 0; m_down = 0;
    end else begin
      m_setup = 0; m_down = 0;
      if (bus_wr) begin
        case (bus_addr)
          12'h00C: m_mask = m_mask | bus_wdata;
          12'h010: m_mask = m_mask & ~bus_wdata;
          12'h014: m_cfg_write(bus_wdata);
          12'h024: m_aqa = bus_wdata;
          12'h028: m_sqb = {32'd0, bus_wdata};
          12'h02C: m_sqb[63:32] = m_sqb[63:32] | bus_wdata;
          12'h030: m_cqb = {32'd0, bus_wdata};
          12'h034: m_cqb[63:32] = m_cqb[63:32] | bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h000: return 32'h0F03_07FF;
      12'h004: return 32'h0040_0020;
      12'h008: return 32'h0001_0100;
      12'h00C, 12'h010: return m_mask;
      12'h014: return m_cc;
      12'h01C: return {28'd0, m_stat};
      12'h024: return m_aqa;
      12'h028: return m_sqb[31:0];
      12'h02C: return m_sqb[63:32];
      12'h030: return m_cqb[31:0];
      12'h034: return m_cqb[63:32];
      default: return 32'd0;
    endcase
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11 read mux vs model", bus_rdata, m_read(bus_addr));
      chk("R10 page size vs model", page_bytes, 64'd1 << (m_cc[10:7] + 12));
      chk("R10 sq entry vs model", sq_entry_bytes, 64'd1 << m_cc[19:16]);
      chk("R10 cq entry vs model", cq_entry_bytes, 64'd1 << m_cc[23:20]);
      chk("R4 setup pulse vs model", admin_setup, m_setup);
      chk("R6 teardown pulse vs model", queue_teardown, m_down);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk); #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  localparam logic [31:0] GOOD = 32'h0046_0001;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state and constants
    rd(12'h014, 32'h0, "R3 config after reset");
    rd(12'h01C, 32'h0, "R4 status after reset");
    rd(12'h000, 32'h0F03_07FF, "R9 capability low");
    rd(12'h004, 32'h0040_0020, "R9 capability high");
    rd(12'h008, 32'h0001_0100, "R9 version");
    chk("R10 reset page size", page_bytes, 32'd4096);

    // interrupt mask
    wr(12'h00C, 32'h0000_00F0);
    rd(12'h00C, 32'h0000_00F0, "R1 mask set read at set offset");
    rd(12'h010, 32'h0000_00F0, "R1 mask set read at clear offset");
    wr(12'h00C, 32'h0000_000F);
    rd(12'h00C, 32'h0000_00FF, "R1 mask OR accumulate");
    wr(12'h010, 32'h0000_003C);
    rd(12'h010, 32'h0000_00C3, "R2 mask clear");

    // admin sizes and bases
    wr(12'h024, 32'h001F_001F);
    rd(12'h024, 32'h001F_001F, "R8 admin sizes");
    wr(12'h028, 32'h0000_1000);
    wr(12'h02C, 32'h0000_0005);
    wr(12'h02C, 32'h0000_0002);
    rd(12'h02C, 32'h0000_0007, "R8 high half OR");
    wr(12'h028, 32'h0000_1000);
    rd(12'h02C, 32'h0000_0000, "R8 low write clears high");
    wr(12'h030, 32'h0000_2000);
    wr(12'h034, 32'h0000_0000);
    rd(12'h030, 32'h0000_2000, "R8 completion base low");

    // plain store
    wr(12'h014, 32'h0046_0000);
    rd(12'h014, 32'h0046_0000, "R3 plain store");
    chk("R10 sq entry bytes", sq_entry_bytes, 16'd64);
    chk("R10 cq entry bytes", cq_entry_bytes, 16'd16);

    // enable with 64 KiB pages: bases misaligned
    wr(12'h014, 32'h0046_0201);
    chk("R5 no setup on misaligned base", admin_setup, 1'b0);
    rd(12'h01C, 32'h2, "R5 fatal on misaligned base");
    chk("R10 page size 64K", page_bytes, 32'd65536);

    // disable after failure
    wr(12'h014, 32'h0);
    chk("R6 teardown on disable", queue_teardown, 1'b1);
    rd(12'h014, 32'h0, "R6 config zeroed");
    rd(12'h01C, 32'h2, "R6 fatal kept on disable");

    // good enable
    wr(12'h014, GOOD);
    chk("R4 setup pulse", admin_setup, 1'b1);
    rd(12'h01C, 32'h1, "R4 ready");
    rd(12'h014, GOOD, "R4 config stored");

    // unlisted offsets
    wr(12'h018, 32'hFFFF_FFFF);
    rd(12'h018, 32'h0, "R11 unlisted reads zero");
    rd(12'h014, GOOD, "R11 unlisted write ignored");
    rd(12'h040, 32'h0, "R11 beyond file reads zero");

    // shutdown request and release
    wr(12'h014, 32'h0046_4001);
    chk("R7 teardown on shutdown", queue_teardown, 1'b1);
    rd(12'h01C, 32'h9, "R7 shutdown complete set");
    wr(12'h014, GOOD);
    rd(12'h01C, 32'h1, "R7 shutdown complete cleared");
    rd(12'h014, GOOD, "R7 config stored on release");
    wr(12'h014, 32'h0);
    rd(12'h01C, 32'h0, "R6 ready cleared");

    // enable together with a shutdown request
    wr(12'h014, 32'h0046_4001);
    chk("R12 no teardown on enable+shutdown", queue_teardown, 1'b0);
    rd(12'h01C, 32'h1, "R12 ready only");

    // disable together with shutdown
    wr(12'h014, 32'h0000_4000);
    rd(12'h01C, 32'h8, "R7 disable with shutdown");
    rd(12'h014, 32'h0000_4000, "R7 disable with shutdown stores data");
    wr(12'h014, 32'h0);
    rd(12'h01C, 32'h0, "R7 release after disable");

    // each remaining validation rule
    wr(12'h014, 32'h0047_0001);
    rd(12'h01C, 32'h2, "R5 bad submission exponent");
    wr(12'h014, 32'h0);
    wr(12'h024, 32'h001F_0000);
    wr(12'h014, GOOD);
    rd(12'h01C, 32'h2, "R5 zero admin size");
    wr(12'h014, 32'h0);
    wr(12'h024, 32'h001F_001F);
    wr(12'h028, 32'h0);
    wr(12'h014, GOOD);
    rd(12'h01C, 32'h2, "R5 zero base");
    wr(12'h014, 32'h0);
    wr(12'h028, 32'h0000_1000);
    wr(12'h014, GOOD);
    rd(12'h01C, 32'h1, "R4 ready after recovery");
    chk("R10 page size 4K", page_bytes, 32'd4096);

    repeat (3) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
    end
  end

endmodule